// File: doc/BRIEF.md
# Systolic Montgomery Modular Multiplier

This block computes a Montgomery product P ≡ A·B·2^-(N+2) (mod M) for an odd N-bit modulus M. No trial division by M is ever done: each iteration adds one multiple of A, selected by one bit of B taken least significant bit first. It then adds M or nothing, so that the running sum becomes even, and halves the sum. The working value is held in carry-save form across a linear chain of N/2+2 processing elements. Each element owns two bit columns and has two register stages, so every register-to-register path holds at most one one-bit full adder plus a gate or two of selection logic. A pipelined parallel-prefix adder then folds the redundant pair into a plain binary result.

Operands may be as large as 2M-1, and the result is always below 2M. An exponentiation controller can therefore feed a product straight back in as an operand with no correction step. R = 2^(N+2) satisfies R > 4M, and the two extra iterations that this R requires take the place of a final subtraction. The block is driven with plain control pins and has no back-pressure. A start pulse in an idle cycle captures A, B and M. Exactly 2N+6+⌈log2(N+4)⌉ rising edges later, a one-cycle done pulse marks a new result. That count is 2N+11 for N from 16 to 28. The result then holds until the next done.

Top module: `mont_systolic_mul`

## Requirements
- R1: When done is high, product·2^(N+2) ≡ a_in·b_in (mod m_in) for the operands captured at the accepted start. This holds for any odd m_in and any a_in, b_in below 2·m_in. a_in and b_in are N+1 bits wide, and bit 0 of b_in is consumed first.
- R2: When done is high, product < 2·m_in, so the result is valid as an operand for a following multiplication.
- R3: A start sampled high on rising edge E0 while idle makes done high in the cycle that begins on rising edge E0+L, where L = 2N+6+⌈log2(N+4)⌉ (43 for N = 16).
- R4: done is high for exactly one cycle per accepted start.
- R5: start is ignored from the accepting edge until the cycle in which done is high. A start during that time causes no extra done, and it changes neither the latency nor the result.
- R6: Operands are captured at the accepting edge, so later changes on a_in, b_in and m_in do not affect the result. product changes only on the edge that raises done, and otherwise holds its value.
- R7: While rst_n is low (asynchronous, active low), done is 0 and product is 0.
- R8: A start presented in the cycle in which done is high is accepted, and its own done follows L edges later.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Begin a multiplication when idle |
| a_in | input | N+1 | Multiplicand, below 2·m_in |
| b_in | input | N+1 | Multiplier, below 2·m_in, consumed LSB first |
| m_in | input | N | Odd modulus |
| done | output | 1 | One-cycle pulse: product is new |
| product | output | N+1 | Montgomery product, below 2·m_in |

## Verification
The product is checked by congruence, product·2^18 ≡ a·b (mod m), together with the bound product < 2m, so the bench never needs a modular inverse. A zero multiplicand shows that no quotient multiple of M is added without cause. Operands at 2M-1 with the largest odd modulus test the carry-save width and the extra iterations that keep the result below 2M. A modulus of 3 tests heavy reduction. A spread of operands from a shift-register sequence, plus a product fed back as the next multiplicand, exercises the bit-serial B feed across all columns. Starts raised while busy, input changes after capture, and a start in the done cycle separate correct capture and busy handling from a design that relatches its inputs.

// File: rtl/mont_pkg.sv
package mont_pkg;

  typedef enum logic [1:0] {
    MS_IDLE = 2'd0,
    MS_RUN  = 2'd1,
    MS_CONV = 2'd2
  } mont_state_e;

  function automatic logic maj3(input logic x, input logic y, input logic z);
    return (x & y) | (x & z) | (y & z);
  endfunction

endpackage

// File: rtl/mont_ctrl.sv
module mont_ctrl
  import mont_pkg::*;
#(
  parameter int ITERS = 18
) (
  input  logic clk,
  input  logic rst_n,
  input  logic start,
  input  logic conv_last,
  output logic accept,
  output logic s1_en,
  output logic s2_en,
  output logic conv_go
);
  localparam int STEPS = 2 * ITERS;
  localparam int CW    = $clog2(STEPS);

  mont_state_e   state;
  logic [CW-1:0] step;

  // R5: a start counts only in the idle state
  assign accept = (state == MS_IDLE) && start;
  assign s1_en  = (state == MS_RUN) && !step[0];
  assign s2_en  = (state == MS_RUN) && step[0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state   <= MS_IDLE;
      step    <= '0;
      conv_go <= 1'b0;
    end else begin
      conv_go <= 1'b0;
      unique case (state)
        MS_IDLE: begin
          if (start) begin
            state <= MS_RUN;
            step  <= '0;
          end
        end
        MS_RUN: begin
          if (step == CW'(STEPS - 1)) begin
            state   <= MS_CONV;
            step    <= '0;
            conv_go <= 1'b1;
          end else begin
            step <= step + 1'b1;
          end
        end
        MS_CONV: begin
          if (conv_last) state <= MS_IDLE;
        end
        default: state <= MS_IDLE;
      endcase
    end
  end
endmodule

// File: rtl/mont_pe.sv
module mont_pe
  import mont_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       clr,
  input  logic       s1_en,
  input  logic       s2_en,
  input  logic       b_bit,
  input  logic       q_bit,
  input  logic [1:0] a_bits,
  input  logic [1:0] m_bits,
  input  logic       xm_lo_i,
  input  logic       ys_hi_i,
  output logic [1:0] xs_o,
  output logic [1:0] xm_o,
  output logic [1:0] ss_o,
  output logic [1:0] sc_o,
  output logic       ys_lo_o
);
  logic [1:0] ss_q, sc_q, xs_q, xm_q;
  logic [1:0] ba, fs1, fc1;
  logic [1:0] xmw, qm, ys, ym;

  // stage 1: running sum plus the selected multiple of A
  assign ba = {2{b_bit}} & a_bits;
  // stage 2: plus the quotient multiple of M; carries of stage 1 enter one column up
  assign xmw = {xm_q[0], xm_lo_i};
  assign qm  = {2{q_bit}} & m_bits;

  always_comb begin
    for (int c = 0; c < 2; c++) begin
      fs1[c] = ss_q[c] ^ sc_q[c] ^ ba[c];
      fc1[c] = maj3(ss_q[c], sc_q[c], ba[c]);
      ys[c]  = xs_q[c] ^ xmw[c] ^ qm[c];
      ym[c]  = maj3(xs_q[c], xmw[c], qm[c]);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ss_q <= '0;
      sc_q <= '0;
      xs_q <= '0;
      xm_q <= '0;
    end else if (clr) begin
      ss_q <= '0;
      sc_q <= '0;
      xs_q <= '0;
      xm_q <= '0;
    end else begin
      if (s1_en) begin
        xs_q <= fs1;
        xm_q <= fc1;
      end
      if (s2_en) begin
        // halving: sum bits move one column down, carries stay in place
        ss_q <= {ys_hi_i, ys[1]};
        sc_q <= ym;
      end
    end
  end

  assign xs_o    = xs_q;
  assign xm_o    = xm_q;
  assign ss_o    = ss_q;
  assign sc_o    = sc_q;
  assign ys_lo_o = ys[0];
endmodule

// File: rtl/mont_cpa.sv
module mont_cpa #(
  parameter int W   = 20,
  parameter int LVL = $clog2(W)
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         go,
  input  logic [W-1:0] va,
  input  logic [W-1:0] vb,
  output logic         last,
  output logic         done,
  output logic         cout,
  output logic [W-1:0] sum
);
  logic [W-1:0] g_q [0:LVL];
  logic [W-1:0] p_q [0:LVL-1];
  logic [W-1:0] h_q [0:LVL];
  logic [LVL:0] v_q;

  function automatic logic [W-1:0] grp_g(input logic [W-1:0] g, input logic [W-1:0] p, input int d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i >= d) ? (g[i] | (p[i] & g[i-d])) : g[i];
    return r;
  endfunction

  function automatic logic [W-1:0] grp_p(input logic [W-1:0] p, input int d);
    logic [W-1:0] r;
    for (int i = 0; i < W; i++) r[i] = (i >= d) ? (p[i] & p[i-d]) : p[i];
    return r;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      g_q[0] <= '0;
      p_q[0] <= '0;
      h_q[0] <= '0;
      v_q[0] <= 1'b0;
    end else begin
      g_q[0] <= va & vb;
      p_q[0] <= va ^ vb;
      h_q[0] <= va ^ vb;
      v_q[0] <= go;
    end
  end

  for (genvar l = 1; l <= LVL; l++) begin : g_lvl
    localparam int D = 1 << (l - 1);
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        g_q[l] <= '0;
        h_q[l] <= '0;
        v_q[l] <= 1'b0;
      end else begin
        g_q[l] <= grp_g(g_q[l-1], p_q[l-1], D);
        h_q[l] <= h_q[l-1];
        v_q[l] <= v_q[l-1];
      end
    end
    if (l < LVL) begin : g_prop
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) p_q[l] <= '0;
        else        p_q[l] <= grp_p(p_q[l-1], D);
      end
    end
  end

  // R6: the result register loads only together with done
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sum  <= '0;
      cout <= 1'b0;
      done <= 1'b0;
    end else begin
      done <= v_q[LVL];
      if (v_q[LVL]) begin
        sum  <= h_q[LVL] ^ {g_q[LVL][W-2:0], 1'b0};
        cout <= g_q[LVL][W-1];
      end
    end
  end

  assign last = v_q[LVL];
endmodule

// File: rtl/mont_systolic_mul.sv
module mont_systolic_mul #(
  parameter int N = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         start,
  input  logic [N:0]   a_in,
  input  logic [N:0]   b_in,
  input  logic [N-1:0] m_in,
  output logic         done,
  output logic [N:0]   product
);
  localparam int W   = N + 4;
  localparam int NPE = W / 2;
  localparam int K   = N + 2;
  localparam int LVL = $clog2(W);

  logic accept, s1_en, s2_en, conv_go, conv_last, cout;
  logic [W-1:0]   a_q, m_q;
  logic [K-1:0]   b_q;
  logic [W-1:0]   xs_all, xm_all, ss_all, sc_all, sum_w;
  logic [NPE-1:0] ys_lo_all;
  logic           q_bit;

  mont_ctrl #(.ITERS(K)) u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .conv_last (conv_last),
    .accept    (accept),
    .s1_en     (s1_en),
    .s2_en     (s2_en),
    .conv_go   (conv_go)
  );

  // R6: operands captured once; B is consumed one bit per iteration, LSB first
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      a_q <= '0;
      m_q <= '0;
      b_q <= '0;
    end else if (accept) begin
      a_q <= W'(a_in);
      m_q <= W'(m_in);
      b_q <= K'(b_in);
    end else if (s2_en) begin
      b_q <= b_q >> 1;
    end
  end

  // quotient bit: parity of the stage-1 sum, column 0 has no incoming carry
  assign q_bit = xs_all[0];

  for (genvar j = 0; j < NPE; j++) begin : g_pe
    logic xm_lo, ys_hi;
    if (j == 0) begin : g_lo
      assign xm_lo = 1'b0;
    end else begin : g_mid
      assign xm_lo = xm_all[2*j-1];
    end
    if (j == NPE - 1) begin : g_top
      assign ys_hi = 1'b0;
    end else begin : g_inner
      assign ys_hi = ys_lo_all[j+1];
    end

    mont_pe u_pe (
      .clk     (clk),
      .rst_n   (rst_n),
      .clr     (accept),
      .s1_en   (s1_en),
      .s2_en   (s2_en),
      .b_bit   (b_q[0]),
      .q_bit   (q_bit),
      .a_bits  (a_q[2*j +: 2]),
      .m_bits  (m_q[2*j +: 2]),
      .xm_lo_i (xm_lo),
      .ys_hi_i (ys_hi),
      .xs_o    (xs_all[2*j +: 2]),
      .xm_o    (xm_all[2*j +: 2]),
      .ss_o    (ss_all[2*j +: 2]),
      .sc_o    (sc_all[2*j +: 2]),
      .ys_lo_o (ys_lo_all[j])
    );
  end

  mont_cpa #(.W(W), .LVL(LVL)) u_cpa (
    .clk   (clk),
    .rst_n (rst_n),
    .go    (conv_go),
    .va    (ss_all),
    .vb    (sc_all),
    .last  (conv_last),
    .done  (done),
    .cout  (cout),
    .sum   (sum_w)
  );

  assign product = sum_w[N:0];
endmodule

// File: rtl/mont_sva.sv
module mont_sva #(
  parameter int N = 16
) (
  input logic         clk,
  input logic         rst_n,
  input logic         accept,
  input logic         done,
  input logic         s2_en,
  input logic         ys0,
  input logic         cout,
  input logic [N+3:0] xs_all,
  input logic [N+3:0] xm_all,
  input logic [N+3:0] sum_w,
  input logic [N+3:0] m_q,
  input logic [N:0]   product
);
  localparam int W   = N + 4;
  localparam int LAT = 2 * N + 6 + $clog2(N + 4);
  localparam int CW  = $clog2(LAT + 2);

  logic          running;
  logic [CW-1:0] lat_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      running <= 1'b0;
      lat_cnt <= '0;
    end else if (accept) begin
      running <= 1'b1;
      lat_cnt <= '0;
    end else if (done) begin
      running <= 1'b0;
    end else if (running) begin
      lat_cnt <= lat_cnt + 1'b1;
    end
  end

  AST_EXACT_HALF: assert property (@(posedge clk) disable iff (!rst_n)
    s2_en |-> !ys0); // R1
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    s2_en |-> (({3'b0, xs_all} + {2'b0, xm_all, 1'b0}) < ({3'b0, m_q} * (W+3)'(5)))); // R1
  AST_RESULT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> ({1'b0, cout, sum_w} < {1'b0, m_q, 1'b0})); // R2
  AST_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (running && lat_cnt == CW'(LAT))); // R3
  AST_DONE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done); // R4
  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    !running |-> !done); // R5
  AST_PRODUCT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !$stable(product) |-> done); // R6
endmodule

bind mont_systolic_mul mont_sva #(.N(N)) u_sva (
  .clk     (clk),
  .rst_n   (rst_n),
  .accept  (accept),
  .done    (done),
  .s2_en   (s2_en),
  .ys0     (ys_lo_all[0]),
  .cout    (cout),
  .xs_all  (xs_all),
  .xm_all  (xm_all),
  .sum_w   (sum_w),
  .m_q     (m_q),
  .product (product)
);

// File: tb/tb_mont_systolic_mul.sv
`timescale 1ns/1ps
module tb_mont_systolic_mul;
  localparam int N   = 16;
  localparam int K   = N + 2;
  localparam int LAT = 2 * N + 11;

  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         start = 1'b0;
  logic [N:0]   a_in = '0;
  logic [N:0]   b_in = '0;
  logic [N-1:0] m_in = 16'd1;
  logic         done;
  logic [N:0]   product;

  int n_run  = 0;
  int n_fail = 0;
  bit finished = 1'b0;
  int unsigned lfsr = 32'h1D872B41;

  always #2 clk = ~clk;

  mont_systolic_mul #(.N(N)) dut (
    .clk     (clk),
    .rst_n   (rst_n),
    .start   (start),
    .a_in    (a_in),
    .b_in    (b_in),
    .m_in    (m_in),
    .done    (done),
    .product (product)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint act, input longint exp);
    n_run++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic summary();
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
  endtask

  // start already driven at the current falling edge
  task automatic wait_done(output int lat);
    int cyc = 0;
    do begin
      @(negedge clk);
      start = 1'b0;
      cyc++;
    end while (!done && cyc < 200);
    lat = cyc - 1;
  endtask

  task automatic check_res(input longint a, input longint b, input longint m, input string tag);
    longint r = longint'(product);
    check(((r << K) % m) == ((a * b) % m), "R1", tag, (r << K) % m, (a * b) % m);
    check(r < 2 * m, "R2", tag, r, 2 * m);
  endtask

  task automatic run_mul(input longint a, input longint b, input longint m, input string tag);
    int lat;
    @(negedge clk);
    a_in = (N+1)'(a); b_in = (N+1)'(b); m_in = N'(m); start = 1'b1;
    wait_done(lat);
    check(lat == LAT, "R3", tag, lat, LAT);
    check_res(a, b, m, tag);
    @(negedge clk);
    check(done == 1'b0, "R4", tag, done, 0);
  endtask

  task automatic t_reset();
    rst_n = 1'b0;
    repeat (3) @(negedge clk);
    check(done == 1'b0 && product == '0, "R7", "in reset", product, 0);
    rst_n = 1'b1;
    @(negedge clk);
    check(done == 1'b0 && product == '0, "R7", "after release", product, 0);
  endtask

  task automatic t_directed();
    run_mul(17'h12345, 17'h0ABCD, 16'hF1D3, "mixed");
    run_mul(0, 17'h1F00F, 16'hF1D3, "zero A");
    run_mul(17'h1FFFD, 17'h1FFFD, 16'hFFFF, "max operands");
    run_mul(5, 5, 3, "modulus 3");
    run_mul(1, 1, 16'h8001, "unit operands");
  endtask

  task automatic t_random();
    for (int i = 0; i < 6; i++) begin
      longint m, a, b;
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      m = longint'(lfsr[15:0] | 16'h0001);
      lfsr = lfsr ^ (lfsr << 13); lfsr = lfsr ^ (lfsr >> 17); lfsr = lfsr ^ (lfsr << 5);
      a = longint'(lfsr[16:0]) % (2 * m);
      b = longint'(lfsr[31:15]) % (2 * m);
      run_mul(a, b, m, $sformatf("spread %0d", i));
    end
  endtask

  task automatic t_chain();
    longint p;
    run_mul(17'h0F0F1, 17'h1A2B3, 16'hE3C5, "chain first");
    p = longint'(product);
    run_mul(p, 17'h1A2B3, 16'hE3C5, "chain fed back");
  endtask

  // R5 and R6: starts while busy and input changes after capture
  task automatic t_ignore_start();
    int cyc = 0;
    bit seen = 1'b0;
    @(negedge clk);
    a_in = 17'h0BEEF; b_in = 17'h10F0F; m_in = 16'hC00B; start = 1'b1;
    do begin
      @(negedge clk);
      cyc++;
      if (cyc >= 5 && cyc < 9) begin
        start = 1'b1; a_in = 17'h00123; b_in = 17'h00456; m_in = 16'h0789;
      end else begin
        start = 1'b0;
      end
    end while (!done && cyc < 200);
    check(cyc - 1 == LAT, "R5", "latency with busy starts", cyc - 1, LAT);
    check_res(17'h0BEEF, 17'h10F0F, 16'hC00B, "operands captured R6");
    for (int i = 0; i < 60; i++) begin
      @(negedge clk);
      if (done) seen = 1'b1;
    end
    check(!seen, "R5", "no extra done", seen, 0);
  endtask

  task automatic t_hold();
    logic [N:0] saved;
    bit moved = 1'b0;
    run_mul(17'h15555, 17'h0AAAA, 16'hD00D, "before hold");
    saved = product;
    for (int i = 0; i < 30; i++) begin
      @(negedge clk);
      a_in = (N+1)'(i * 977); b_in = (N+1)'(i * 131); m_in = N'(i * 2 + 1);
      if (product != saved) moved = 1'b1;
    end
    check(!moved, "R6", "product holds", product, saved);
  endtask

  task automatic t_back2back();
    int lat1, lat2;
    @(negedge clk);
    a_in = 17'h1C001; b_in = 17'h03FFF; m_in = 16'hE001; start = 1'b1;
    wait_done(lat1);
    check(lat1 == LAT, "R3", "b2b first latency", lat1, LAT);
    check_res(17'h1C001, 17'h03FFF, 16'hE001, "b2b first");
    a_in = 17'h00777; b_in = 17'h1ABCD; m_in = 16'hD5A5; start = 1'b1;
    wait_done(lat2);
    check(lat2 == LAT, "R8", "start in done cycle", lat2, LAT);
    check_res(17'h00777, 17'h1ABCD, 16'hD5A5, "b2b second R8");
  endtask

  initial begin
    t_reset();
    t_directed();
    t_random();
    t_chain();
    t_ignore_start();
    t_hold();
    t_back2back();
    finished = 1'b1;
    summary();
    $finish;
  end

  initial begin
    #(4 * 150000);
    if (!finished) begin
      n_run++;
      n_fail++;
      $display("FAIL R3 watchdog: actual timeout expected completion");
      summary();
      $finish;
    end
  end
endmodule